// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This controller lets synchronous logic read and write an asynchronous byte-wide static RAM of 8192 locations. The requester presents a valid strobe with a read/write flag, an address and write data. The controller then runs a fixed sequence of clocked phases on the memory pins and answers with a one-cycle done pulse. For a read, the captured byte is on the read-data output during that pulse.

The memory side has a 13-bit address and a pair of chip selects of opposite polarity. It also has an active-low output enable and an active-low write enable. The shared data pins are split into an output byte, a drive-enable and an input byte, so that the pad ring can join them. The required nanosecond limits are turned into clock counts at elaboration, using the clock period parameter. These limits are access time, write pulse width, data and address setup to the end of the write, minimum write cycle and bus release. Between operations both chip selects are inactive, which puts the memory in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While the active-high synchronous reset is high and whenever the controller is idle, `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_doe`=0 and `ready`=0.
- R2: A read holds `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for RD = max(1, ceil(T_AA/T_CLK)) cycles. It then samples `mem_din`, which must be at least T_AA after the address and controls were applied. `ready` becomes visible 1+RD clock edges after the edge that accepts the request.
- R3: A write asserts both chip selects and drives the address and data one cycle before `mem_we_n` falls. `mem_we_n` stays low for WP = max(1, ceil(max(T_PWE, T_SD, T_AW−T_CLK, T_WC−2·T_CLK)/T_CLK)) cycles, so data setup is at least T_SD, address setup at least T_AW and the pulse at least T_PWE. The rising edge of `mem_we_n` stores the byte, and `ready` is visible 2+WP edges after acceptance.
- R4: `mem_oe_n` and `mem_we_n` are never low together, and `mem_oe_n` stays high for the whole write.
- R5: `mem_doe` is never high while `mem_oe_n` is low. It rises only after `mem_oe_n` has been high for TA = max(1, ceil(T_HZ/T_CLK)) cycles, so the controller never drives into the bus-release window of the memory.
- R6: Address and data stay unchanged across the rising edge of `mem_we_n`. `mem_doe` falls exactly one clock period after that edge.
- R7: `ready` is a single-cycle pulse, one per accepted request. For reads, `rdata` carries the addressed byte while `ready` is high.
- R8: A request is accepted only while the controller is idle. A `req_valid` pulse during an operation has no effect on the memory or the address lines.
- R9: Every one of the 2^ADDR_W locations can be written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read byte |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dout | output | DATA_W | Byte driven onto the data pins |
| mem_doe | output | 1 | Data pin drive enable |
| mem_din | input | DATA_W | Byte sampled from the data pins |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the controller with ADDR_W=8 and the default 20 ns clock. This gives RD=3, WP=2 and TA=1. With the smaller address width, a full write sweep, a full read-back, a partial overwrite and a second read-back of every location fit in a short run. A timed memory model returns unknown data until the access time has passed. It also measures setup, pulse width, hold and bus-release windows in nanoseconds at each write edge, which brings the rounding of each limit within reach of a check.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 20,
  parameter int T_AA_NS  = 55,
  parameter int T_PWE_NS = 25,
  parameter int T_SD_NS  = 25,
  parameter int T_AW_NS  = 40,
  parameter int T_WC_NS  = 50,
  parameter int T_HZ_NS  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = to_cyc(T_AA_NS);
  localparam int WP_CYC = to_cyc(imax(imax(T_PWE_NS, T_SD_NS),
                                      imax(T_AW_NS - CLK_NS, T_WC_NS - 2 * CLK_NS)));
  localparam int TA_CYC = to_cyc(T_HZ_NS);
  localparam int CW     = $clog2(imax(imax(RD_CYC, WP_CYC), TA_CYC) + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ACC, S_RD_CAP, S_WR_SET, S_WR_PULSE, S_TURN
  } phase_t;

  phase_t          state, nxt;
  logic [CW-1:0]   cnt, cnt_load;
  logic [CW-1:0]   oe_hi;
  logic            rel_ok;

  assign rel_ok = (oe_hi == CW'(TA_CYC));

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:     if (req_valid) nxt = req_write ? S_WR_SET : S_RD_ACC;
      S_RD_ACC:   if (cnt == '0) nxt = S_RD_CAP;
      S_RD_CAP:   nxt = S_TURN;
      S_WR_SET:   if (mem_doe) nxt = S_WR_PULSE;
      S_WR_PULSE: if (cnt == '0) nxt = S_TURN;
      S_TURN:     if (cnt == '0) nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      S_RD_ACC:   cnt_load = CW'(RD_CYC - 1);
      S_WR_PULSE: cnt_load = CW'(WP_CYC - 1);
      S_TURN:     cnt_load = CW'(TA_CYC - 1);
      default:    cnt_load = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      oe_hi     <= '0;
      mem_addr  <= '0;
      mem_dout  <= '0;
      rdata     <= '0;
      ready     <= 1'b0;
      mem_doe   <= 1'b0;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
    end else begin
      state <= nxt;
      if (nxt != state)   cnt <= cnt_load;
      else if (cnt != '0) cnt <= cnt - 1'b1;

      if (!mem_oe_n)   oe_hi <= '0;
      else if (!rel_ok) oe_hi <= oe_hi + 1'b1;

      if (state == S_IDLE && req_valid) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      if (state == S_RD_ACC && nxt == S_RD_CAP) rdata <= mem_din;

      ready     <= (state == S_RD_ACC && nxt == S_RD_CAP) ||
                   (state == S_WR_PULSE && nxt == S_TURN);
      mem_ce1_n <= (nxt == S_IDLE);
      mem_ce2   <= (nxt != S_IDLE);
      mem_oe_n  <= (nxt != S_RD_ACC);
      mem_we_n  <= (nxt != S_WR_PULSE);
      mem_doe   <= ((nxt == S_WR_SET || nxt == S_WR_PULSE) && rel_ok) ||
                   (state == S_WR_PULSE && nxt == S_TURN);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_doe && !ready)); // R1
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_doe)); // R3
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_doe |-> mem_oe_n); // R5
  AST_DRIVE_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_doe) |-> $past(mem_oe_n)); // R5
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_doe && $stable(mem_dout) && $stable(mem_addr))); // R6
  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> !mem_doe); // R6
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready); // R7
  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !mem_ce1_n |=> $stable(mem_addr)); // R8

endmodule

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
  localparam int AW  = 8;
  localparam int CLK = 20;
  localparam int RD  = (55 + CLK - 1) / CLK;
  localparam int WP  = 2;
  localparam int TA  = (20 + CLK - 1) / CLK;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic ready, mem_doe, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;
  logic [7:0] rdata, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;

  int vectors = 0, miscompares = 0, contention = 0;
  logic [7:0] mem [0:(1<<AW)-1];
  realtime t_addr = 0, t_wef = 0, t_data = 0, t_oer = -100, t_rd = 0, t_wer = -100;

  always #(CLK/2) clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(8), .CLK_NS(CLK)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int pass);
    return 8'((a * 37 + 11) ^ (pass * 8'h5A));
  endfunction

  always @(mem_addr) t_addr = $realtime;
  always @(mem_dout or mem_doe) t_data = $realtime;
  always @(negedge mem_we_n) t_wef = $realtime;
  always @(posedge mem_oe_n) t_oer = $realtime;
  always @(mem_addr or mem_oe_n or mem_ce1_n or mem_ce2 or mem_we_n) t_rd = $realtime;

  always @(posedge mem_we_n) begin
    t_wer = $realtime;
    if (!mem_ce1_n && mem_ce2) begin
      chk("R3 data setup", 32'(($realtime - t_data >= 25) && mem_doe), 1);
      chk("R3 address setup", 32'($realtime - t_addr >= 40), 1);
      chk("R3 pulse width", 32'($realtime - t_wef >= 25), 1);
      mem[mem_addr] = mem_dout;
    end
  end

  always @(negedge mem_doe)
    if (!rst) chk("R6 drive release", 32'(($realtime - t_wer) > CLK - 0.1 && ($realtime - t_wer) < CLK + 0.1), 1);

  initial begin
    mem_din = 'x;
    #0.5;
    forever begin
      #1;
      if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n && ($realtime - t_rd >= 55))
        mem_din = mem[mem_addr];
      else
        mem_din = 'x;
      if (mem_doe && ((!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) || ($realtime - t_oer < 20)))
        contention++;
    end
  end

  task automatic op(input bit w, input int a, input logic [7:0] d, output logic [7:0] rd);
    int lat;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (!ready && lat < 40) begin @(negedge clk); lat++; end
    rd = rdata;
    if (w) chk("R3 write latency", 32'(lat), 32'(2 + WP));
    else   chk("R2 read latency", 32'(lat), 32'(1 + RD));
    @(negedge clk);
    chk("R7 single-cycle ready", 32'(ready), 0);
    repeat (TA) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk("R1 reset ce1_n", 32'(mem_ce1_n), 1);
    chk("R1 reset ce2", 32'(mem_ce2), 0);
    chk("R1 reset oe_n/we_n", 32'({mem_oe_n, mem_we_n}), 3);
    chk("R1 reset doe/ready", 32'({mem_doe, ready}), 0);
    rst = 0;
    repeat (2) @(negedge clk);

    for (int a = 0; a < (1 << AW); a++) op(1, a, pat(a, 0), r);
    for (int a = 0; a < (1 << AW); a++) begin
      op(0, a, 8'h00, r);
      chk("R2 R7 R9 read data", 32'(r), 32'(pat(a, 0)));
    end
    chk("R1 standby after op", 32'({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_doe}), 32'b10110);

    for (int a = 0; a < (1 << AW); a += 2) op(1, a, pat(a, 1), r);
    for (int a = 0; a < (1 << AW); a++) begin
      op(0, a, 8'h00, r);
      chk("R9 mixed readback", 32'(r), 32'(pat(a, a % 2 == 0 ? 1 : 0)));
    end

    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'd3; req_wdata = 8'h3C;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'd4; req_wdata = 8'hC3;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'd5;
    chk("R8 address held while busy", 32'(mem_addr), 3);
    @(negedge clk);
    req_valid = 0;
    repeat (8) @(negedge clk);
    op(0, 4, 8'h00, r);
    chk("R8 busy request ignored", 32'(r), 32'(pat(4, 1)));
    op(0, 3, 8'h00, r);
    chk("R8 accepted write stored", 32'(r), 32'h3C);

    chk("R4 R5 no bus contention", 32'(contention), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    vectors++; miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule